// File: doc/BRIEF.md
# Layer 1 Activation Control

This block sequences the physical layer of a basic-rate digital subscriber line through its quiet, waking, activating and active phases. Two sources drive it. A line receiver reports which signal type arrives on the wire as a 2-bit code. A processor writes 4-bit commands, each qualified by a one-cycle valid. The block keeps a 4-bit indication for the processor to read, selects which signal type the transmitter sends, and drives an enable for the block's internal clock tree.

After reset the indication is 1111. Once the processor has read that value, signalled by a one-cycle read strobe, a long timer begins to run. It runs only while the line stays silent (INFO 0). When it expires, the block gates its own clocks off. A line wake-up detector keeps running in that low-power state and flags any line activity through the indication. The clocks return only when the processor issues the enable-clock command, and then only after a start-up delay. Both intervals are parameters counted in reference-clock cycles.

The processor also has a set of special commands. One is a layer 1 reset that can be issued from any state. The others request analog loopback, send a continuous stream of zeros, or send a single zero pulse. Line events can also drive transitions: a normal activation handshake moves the block from idle through pending and synchronising to activated.

Top module: `l1act_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `ind_code`=1111, `clk_en`=1, `tx_info`=00 (INFO 0), `loop_en`=0 and `zero_pulse`=0.
- R2: Command 0001 (layer 1 reset) accepted in any state gives `ind_code`=1111, `clk_en`=1 and `tx_info`=00 on the next cycle. It also disarms the clock-off timer, so a new read strobe is needed to arm it again.
- R3: In the post-reset state, `clk_en` falls to 0 with `ind_code`=0110 exactly OFF_CYC cycles after the clock edge that samples `ind_rd`, provided `rx_info`=00 (INFO 0) throughout. Without a read strobe the clocks never turn off.
- R4: An `rx_info` value other than 00 in the post-reset state clears the clock-off count. The full OFF_CYC interval then restarts from the next INFO 0 cycle.
- R5: While clocks are off, `ind_code` is 1000 in the cycle after `rx_info`≠00 and 0110 in the cycle after `rx_info`=00. `clk_en` stays 0, `tx_info` stays 00, and `loop_en` and `zero_pulse` stay 0.
- R6: Command 1100 (enable clock) in the clock-off state gives `ind_code`=0111 with `clk_en`=0 for WAKE_CYC cycles, then `ind_code`=0000 with `clk_en`=1. Issued in the post-reset state, it gives `ind_code`=0000 on the next cycle.
- R7: From idle (0000), command 1000 gives `tx_info`=01 (INFO 1) and `ind_code`=1001. `rx_info`=10 (INFO 2) in idle or pending gives `tx_info`=10 (INFO 3) and `ind_code`=1101. `rx_info`=11 (INFO 4) in that state gives `ind_code`=1100.
- R8: In the activated state, `rx_info`=00 returns the block to idle (`ind_code`=0000, `tx_info`=00). Command 0011 returns pending, synchronising, activated, loopback and zeros states to idle.
- R9: Command 1010 in idle sets `loop_en`=1, `tx_info`=10 and `ind_code`=1010 until command 0011 arrives.
- R10: Command 0100 in idle sets `tx_info`=11 (continuous zeros) and `ind_code`=0100 until command 0011 arrives.
- R11: Command 0010 in idle raises `zero_pulse` for exactly one cycle and leaves the state unchanged.
- R12: Commands not listed for the current state, and undefined codes, leave every output unchanged.
- R13: When a command and a line or timer event fall in the same cycle, an accepted command decides the next state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle qualifier for `cmd_code` |
| cmd_code | input | 4 | Processor command |
| rx_info | input | 2 | Received signal: 00 INFO 0, 01 unrecognised, 10 INFO 2, 11 INFO 4 |
| ind_rd | input | 1 | One-cycle strobe: indication has been read |
| ind_code | output | 4 | Indication to the processor |
| clk_en | output | 1 | Internal clock enable |
| tx_info | output | 2 | Signal to send: 00 INFO 0, 01 INFO 1, 10 INFO 3, 11 zeros |
| loop_en | output | 1 | Analog loopback enable |
| zero_pulse | output | 1 | One-cycle single-zero request |

## Verification
Every output is a register. A command, line code or read strobe sampled at one edge therefore shows its effect one cycle later. The bench drives inputs on the falling edge and samples outputs at the next falling edge. The two timers are the exception: a result falls due OFF_CYC or WAKE_CYC edges after the sampling edge. The bench runs exactly one cycle short of that count, checks that nothing has changed yet, and then steps once more to check the transition. The random phase keeps a bench model one step ahead and compares all four outputs after every cycle.

// File: rtl/l1act_pkg.sv
package l1act_pkg;

  localparam logic [3:0] CMD_RST   = 4'b0001;
  localparam logic [3:0] CMD_ONEZ  = 4'b0010;
  localparam logic [3:0] CMD_DEACT = 4'b0011;
  localparam logic [3:0] CMD_ZEROS = 4'b0100;
  localparam logic [3:0] CMD_ACT   = 4'b1000;
  localparam logic [3:0] CMD_LOOP  = 4'b1010;
  localparam logic [3:0] CMD_ECK   = 4'b1100;

  localparam logic [3:0] IND_IDLE  = 4'b0000;
  localparam logic [3:0] IND_ZERO  = 4'b0100;
  localparam logic [3:0] IND_OFF   = 4'b0110;
  localparam logic [3:0] IND_WAKE  = 4'b0111;
  localparam logic [3:0] IND_SIG   = 4'b1000;
  localparam logic [3:0] IND_PEND  = 4'b1001;
  localparam logic [3:0] IND_LOOP  = 4'b1010;
  localparam logic [3:0] IND_ACT   = 4'b1100;
  localparam logic [3:0] IND_SYNC  = 4'b1101;
  localparam logic [3:0] IND_RESET = 4'b1111;

  localparam logic [1:0] RX_INFO0 = 2'b00;
  localparam logic [1:0] RX_INFO2 = 2'b10;
  localparam logic [1:0] RX_INFO4 = 2'b11;

  localparam logic [1:0] TX_INFO0 = 2'b00;
  localparam logic [1:0] TX_INFO1 = 2'b01;
  localparam logic [1:0] TX_INFO3 = 2'b10;
  localparam logic [1:0] TX_ZEROS = 2'b11;

  typedef enum logic [3:0] {
    ST_RESET, ST_OFF, ST_WAKE, ST_IDLE, ST_PEND,
    ST_SYNC, ST_ACT, ST_LOOP, ST_ZERO
  } l1_state_e;

  typedef struct packed {
    logic rst;
    logic eck;
    logic act;
    logic deact;
    logic loop;
    logic zeros;
    logic onez;
  } l1_cmd_t;

  function automatic logic [1:0] tx_of(l1_state_e st);
    case (st)
      ST_PEND:                   return TX_INFO1;
      ST_SYNC, ST_ACT, ST_LOOP:  return TX_INFO3;
      ST_ZERO:                   return TX_ZEROS;
      default:                   return TX_INFO0;
    endcase
  endfunction

endpackage

// File: rtl/l1act_cmd_decode.sv
module l1act_cmd_decode
  import l1act_pkg::*;
(
  input  logic       valid,
  input  logic [3:0] code,
  output l1_cmd_t    cmd
);
  always_comb begin
    cmd = '0;
    if (valid) begin
      case (code)
        CMD_RST:   cmd.rst   = 1'b1;
        CMD_ECK:   cmd.eck   = 1'b1;
        CMD_ACT:   cmd.act   = 1'b1;
        CMD_DEACT: cmd.deact = 1'b1;
        CMD_LOOP:  cmd.loop  = 1'b1;
        CMD_ZEROS: cmd.zeros = 1'b1;
        CMD_ONEZ:  cmd.onez  = 1'b1;
        default:   cmd       = '0;
      endcase
    end
  end
endmodule

// File: rtl/l1act_cycle_timer.sv
module l1act_cycle_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || done) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/l1act_fsm.sv
module l1act_fsm
  import l1act_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  l1_cmd_t    cmd,
  input  logic [1:0] rx_info,
  input  logic       ind_rd,
  input  logic       off_done,
  input  logic       wake_done,
  output logic       off_run,
  output logic       wake_run,
  output logic [3:0] ind_code,
  output logic       clk_en,
  output logic [1:0] tx_info,
  output logic       loop_en,
  output logic       zero_pulse
);
  l1_state_e  state, nxt;
  logic [3:0] nxt_ind;
  logic       armed, nxt_armed, nxt_pulse;

  assign off_run  = (state == ST_RESET) && armed && (rx_info == RX_INFO0);
  assign wake_run = (state == ST_WAKE);

  always_comb begin
    nxt       = state;
    nxt_ind   = ind_code;
    nxt_pulse = 1'b0;
    nxt_armed = armed;
    case (state)
      ST_RESET: begin
        nxt_ind = IND_RESET;
        if (ind_rd) nxt_armed = 1'b1;
        if (cmd.eck) begin
          nxt = ST_IDLE; nxt_ind = IND_IDLE;
        end else if (off_done) begin
          nxt = ST_OFF; nxt_ind = IND_OFF;
        end
      end
      ST_OFF: begin
        if (cmd.eck) begin
          nxt = ST_WAKE; nxt_ind = IND_WAKE;
        end else begin
          nxt_ind = (rx_info == RX_INFO0) ? IND_OFF : IND_SIG;
        end
      end
      ST_WAKE: begin
        if (wake_done) begin
          nxt = ST_IDLE; nxt_ind = IND_IDLE;
        end
      end
      ST_IDLE: begin
        if (cmd.act) begin
          nxt = ST_PEND; nxt_ind = IND_PEND;
        end else if (cmd.loop) begin
          nxt = ST_LOOP; nxt_ind = IND_LOOP;
        end else if (cmd.zeros) begin
          nxt = ST_ZERO; nxt_ind = IND_ZERO;
        end else if (cmd.onez) begin
          nxt_pulse = 1'b1;
        end else if (rx_info == RX_INFO2) begin
          nxt = ST_SYNC; nxt_ind = IND_SYNC;
        end
      end
      ST_PEND: begin
        if (cmd.deact) begin
          nxt = ST_IDLE; nxt_ind = IND_IDLE;
        end else if (rx_info == RX_INFO2) begin
          nxt = ST_SYNC; nxt_ind = IND_SYNC;
        end
      end
      ST_SYNC: begin
        if (cmd.deact) begin
          nxt = ST_IDLE; nxt_ind = IND_IDLE;
        end else if (rx_info == RX_INFO4) begin
          nxt = ST_ACT; nxt_ind = IND_ACT;
        end
      end
      ST_ACT: begin
        if (cmd.deact || rx_info == RX_INFO0) begin
          nxt = ST_IDLE; nxt_ind = IND_IDLE;
        end
      end
      ST_LOOP, ST_ZERO: begin
        if (cmd.deact) begin
          nxt = ST_IDLE; nxt_ind = IND_IDLE;
        end
      end
      default: begin
        nxt = ST_RESET; nxt_ind = IND_RESET;
      end
    endcase
    if (cmd.rst) begin
      nxt       = ST_RESET;
      nxt_ind   = IND_RESET;
      nxt_pulse = 1'b0;
    end
    if (nxt != ST_RESET || cmd.rst) nxt_armed = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_RESET;
      ind_code   <= IND_RESET;
      armed      <= 1'b0;
      clk_en     <= 1'b1;
      tx_info    <= TX_INFO0;
      loop_en    <= 1'b0;
      zero_pulse <= 1'b0;
    end else begin
      state      <= nxt;
      ind_code   <= nxt_ind;
      armed      <= nxt_armed;
      clk_en     <= !(nxt == ST_OFF || nxt == ST_WAKE);
      tx_info    <= tx_of(nxt);
      loop_en    <= (nxt == ST_LOOP);
      zero_pulse <= nxt_pulse;
    end
  end
endmodule

// File: rtl/l1act_ctrl.sv
module l1act_ctrl
  import l1act_pkg::*;
#(
  parameter int OFF_CYC  = 714240,
  parameter int WAKE_CYC = 7680
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [3:0] cmd_code,
  input  logic [1:0] rx_info,
  input  logic       ind_rd,
  output logic [3:0] ind_code,
  output logic       clk_en,
  output logic [1:0] tx_info,
  output logic       loop_en,
  output logic       zero_pulse
);
  l1_cmd_t cmd;
  logic    off_run, off_done, wake_run, wake_done;

  l1act_cmd_decode u_dec (
    .valid (cmd_valid),
    .code  (cmd_code),
    .cmd   (cmd)
  );

  l1act_cycle_timer #(.LIMIT(OFF_CYC)) u_off_tmr (
    .clk  (clk),
    .rst  (rst),
    .run  (off_run),
    .done (off_done)
  );

  l1act_cycle_timer #(.LIMIT(WAKE_CYC)) u_wake_tmr (
    .clk  (clk),
    .rst  (rst),
    .run  (wake_run),
    .done (wake_done)
  );

  l1act_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .cmd        (cmd),
    .rx_info    (rx_info),
    .ind_rd     (ind_rd),
    .off_done   (off_done),
    .wake_done  (wake_done),
    .off_run    (off_run),
    .wake_run   (wake_run),
    .ind_code   (ind_code),
    .clk_en     (clk_en),
    .tx_info    (tx_info),
    .loop_en    (loop_en),
    .zero_pulse (zero_pulse)
  );
endmodule

// File: rtl/l1act_ctrl_chk.sv
module l1act_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [3:0] cmd_code,
  input logic [3:0] ind_code,
  input logic       clk_en,
  input logic [1:0] tx_info,
  input logic       loop_en,
  input logic       zero_pulse
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (ind_code == 4'b1111 && clk_en && tx_info == 2'b00 && !loop_en && !zero_pulse));

  assert_reset_cmd_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == 4'b0001) |=> (ind_code == 4'b1111 && clk_en && tx_info == 2'b00));

  assert_clk_off_ind_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_en) |-> (ind_code == 4'b0110));

  assert_off_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !clk_en |-> (tx_info == 2'b00 && !loop_en && !zero_pulse));

  assert_clk_back_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_en) |-> (ind_code == 4'b0000 || ind_code == 4'b1111));

  assert_loop_out_R9: assert property (@(posedge clk) disable iff (rst)
    loop_en |-> (ind_code == 4'b1010 && tx_info == 2'b10));

  assert_zeros_out_R10: assert property (@(posedge clk) disable iff (rst)
    (tx_info == 2'b11) |-> (ind_code == 4'b0100));

  assert_one_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    zero_pulse |=> !zero_pulse);
endmodule

bind l1act_ctrl l1act_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .cmd_code   (cmd_code),
  .ind_code   (ind_code),
  .clk_en     (clk_en),
  .tx_info    (tx_info),
  .loop_en    (loop_en),
  .zero_pulse (zero_pulse)
);

// File: tb/l1act_ctrl_tb_top.sv
module l1act_ctrl_tb_top;
  localparam int OFF_CYC  = 40;
  localparam int WAKE_CYC = 12;

  localparam logic [3:0] C_RST = 4'b0001, C_ONEZ = 4'b0010, C_DEACT = 4'b0011,
                         C_ZEROS = 4'b0100, C_ACT = 4'b1000, C_LOOP = 4'b1010,
                         C_ECK = 4'b1100;

  localparam int M_IDLE = 0, M_PEND = 1, M_SYNC = 2, M_ACT = 3, M_LOOP = 4, M_ZERO = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_code = 4'd0;
  logic [1:0] rx_info = 2'd0;
  logic       ind_rd = 1'b0;
  logic [3:0] ind_code;
  logic       clk_en;
  logic [1:0] tx_info;
  logic       loop_en;
  logic       zero_pulse;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  l1act_ctrl #(.OFF_CYC(OFF_CYC), .WAKE_CYC(WAKE_CYC)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .rx_info(rx_info), .ind_rd(ind_rd), .ind_code(ind_code), .clk_en(clk_en),
    .tx_info(tx_info), .loop_en(loop_en), .zero_pulse(zero_pulse)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit v, logic [3:0] code, logic [1:0] rx, bit rd);
    cmd_valid = v; cmd_code = code; rx_info = rx; ind_rd = rd;
    @(negedge clk);
    cmd_valid = 1'b0; ind_rd = 1'b0;
  endtask

  task automatic idle(int n, logic [1:0] rx);
    for (int i = 0; i < n; i++) step(1'b0, 4'd0, rx, 1'b0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic int m_next(int st, bit v, logic [3:0] c, logic [1:0] rx);
    case (st)
      M_IDLE: begin
        if (v && c == C_ACT)   return M_PEND;
        if (v && c == C_LOOP)  return M_LOOP;
        if (v && c == C_ZEROS) return M_ZERO;
        if (v && c == C_ONEZ)  return M_IDLE;
        if (rx == 2'b10)       return M_SYNC;
        return M_IDLE;
      end
      M_PEND: begin
        if (v && c == C_DEACT) return M_IDLE;
        if (rx == 2'b10)       return M_SYNC;
        return M_PEND;
      end
      M_SYNC: begin
        if (v && c == C_DEACT) return M_IDLE;
        if (rx == 2'b11)       return M_ACT;
        return M_SYNC;
      end
      M_ACT: begin
        if ((v && c == C_DEACT) || rx == 2'b00) return M_IDLE;
        return M_ACT;
      end
      default: return (v && c == C_DEACT) ? M_IDLE : st;
    endcase
  endfunction

  function automatic int m_ind(int st);
    case (st)
      M_PEND: return 9;
      M_SYNC: return 13;
      M_ACT:  return 12;
      M_LOOP: return 10;
      M_ZERO: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int m_tx(int st);
    case (st)
      M_PEND: return 1;
      M_SYNC, M_ACT, M_LOOP: return 2;
      M_ZERO: return 3;
      default: return 0;
    endcase
  endfunction

  initial begin
    #2000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 ind", ind_code, 15); chk("R1 clk_en", clk_en, 1);
    chk("R1 tx", tx_info, 0); chk("R1 loop", loop_en, 0); chk("R1 pulse", zero_pulse, 0);

    // R3 no read: clocks never stop
    idle(OFF_CYC + 5, 2'b00);
    chk("R3 unread clk_en", clk_en, 1);
    // R3 timer after read
    step(1'b0, 4'd0, 2'b00, 1'b1);
    idle(OFF_CYC - 1, 2'b00);
    chk("R3 before expiry", clk_en, 1);
    idle(1, 2'b00);
    chk("R3 clk_en off", clk_en, 0); chk("R3 ind off", ind_code, 6);

    // R5 wake detector while off
    idle(1, 2'b01);
    chk("R5 ind sig", ind_code, 8); chk("R5 clk_en", clk_en, 0); chk("R5 tx", tx_info, 0);
    idle(1, 2'b00);
    chk("R5 ind quiet", ind_code, 6);

    // R12 activation ignored while off
    step(1'b1, C_ACT, 2'b00, 1'b0);
    chk("R12 act when off", ind_code, 6); chk("R12 tx when off", tx_info, 0);

    // R6 enable clock with start-up delay
    step(1'b1, C_ECK, 2'b00, 1'b0);
    chk("R6 ind wake", ind_code, 7); chk("R6 clk during wake", clk_en, 0);
    idle(WAKE_CYC - 1, 2'b00);
    chk("R6 still waking", clk_en, 0); chk("R6 ind still wake", ind_code, 7);
    idle(1, 2'b00);
    chk("R6 clk back", clk_en, 1); chk("R6 ind idle", ind_code, 0);

    // R4 line activity restarts the count
    do_reset();
    step(1'b0, 4'd0, 2'b00, 1'b1);
    idle(20, 2'b00);
    idle(1, 2'b10);
    idle(OFF_CYC - 1, 2'b00);
    chk("R4 restarted count", clk_en, 1);
    idle(1, 2'b00);
    chk("R4 off after full interval", clk_en, 0);

    // R13 enable clock wins over expiring timer; R6 from post-reset
    do_reset();
    step(1'b0, 4'd0, 2'b00, 1'b1);
    idle(OFF_CYC - 1, 2'b00);
    step(1'b1, C_ECK, 2'b00, 1'b0);
    chk("R13 eck beats timer ind", ind_code, 0); chk("R13 eck beats timer clk", clk_en, 1);

    // R7 activation handshake, R13 command beats INFO 2
    step(1'b1, C_ACT, 2'b10, 1'b0);
    chk("R7 pend ind", ind_code, 9); chk("R7 pend tx", tx_info, 1);
    step(1'b0, 4'd0, 2'b10, 1'b0);
    chk("R7 sync ind", ind_code, 13); chk("R7 sync tx", tx_info, 2);
    step(1'b0, 4'd0, 2'b11, 1'b0);
    chk("R7 act ind", ind_code, 12); chk("R7 act tx", tx_info, 2);
    // R8 loss of signal
    step(1'b0, 4'd0, 2'b00, 1'b0);
    chk("R8 info0 ind", ind_code, 0); chk("R8 info0 tx", tx_info, 0);

    // R9 loopback
    step(1'b1, C_LOOP, 2'b00, 1'b0);
    chk("R9 loop_en", loop_en, 1); chk("R9 ind", ind_code, 10); chk("R9 tx", tx_info, 2);
    step(1'b1, C_ACT, 2'b00, 1'b0);
    chk("R12 act in loop", ind_code, 10);
    step(1'b1, C_DEACT, 2'b00, 1'b0);
    chk("R9 loop released", loop_en, 0); chk("R8 deact from loop", ind_code, 0);

    // R10 continuous zeros
    step(1'b1, C_ZEROS, 2'b00, 1'b0);
    chk("R10 tx", tx_info, 3); chk("R10 ind", ind_code, 4);
    step(1'b1, C_DEACT, 2'b00, 1'b0);
    chk("R10 released", tx_info, 0);

    // R11 single zero, R13 command beats INFO 2
    step(1'b1, C_ONEZ, 2'b10, 1'b0);
    chk("R11 pulse", zero_pulse, 1); chk("R13 onez keeps idle", ind_code, 0);
    step(1'b0, 4'd0, 2'b00, 1'b0);
    chk("R11 pulse ends", zero_pulse, 0);

    // R12 undefined code in idle
    step(1'b1, 4'b1111, 2'b00, 1'b0);
    chk("R12 undefined code", ind_code, 0);

    // R8 deactivate from activated
    step(1'b1, C_ACT, 2'b00, 1'b0);
    step(1'b0, 4'd0, 2'b10, 1'b0);
    step(1'b0, 4'd0, 2'b11, 1'b0);
    step(1'b1, C_DEACT, 2'b11, 1'b0);
    chk("R8 deact from act", ind_code, 0);

    // R2 reset command from activated, then disarmed
    step(1'b1, C_ACT, 2'b00, 1'b0);
    step(1'b0, 4'd0, 2'b10, 1'b0);
    step(1'b0, 4'd0, 2'b11, 1'b0);
    step(1'b1, C_RST, 2'b11, 1'b0);
    chk("R2 ind", ind_code, 15); chk("R2 clk", clk_en, 1); chk("R2 tx", tx_info, 0);
    idle(OFF_CYC + 3, 2'b00);
    chk("R2 timer disarmed", clk_en, 1);
    // R2 from clock-off state
    step(1'b0, 4'd0, 2'b00, 1'b1);
    idle(OFF_CYC, 2'b00);
    chk("R2 setup off", clk_en, 0);
    step(1'b1, C_RST, 2'b00, 1'b0);
    chk("R2 from off clk", clk_en, 1); chk("R2 from off ind", ind_code, 15);

    // Random phase over the clocked states
    step(1'b1, C_ECK, 2'b00, 1'b0);
    begin
      int ms;
      void'($urandom(32'd20240611));
      ms = M_IDLE;
      for (int i = 0; i < 400; i++) begin
        bit v;
        logic [3:0] c;
        logic [1:0] rx;
        int ezp;
        v  = 1'($urandom % 2);
        c  = 4'($urandom % 16);
        if (c == C_RST) c = C_DEACT;
        rx = 2'($urandom % 4);
        ezp = (ms == M_IDLE && v && c == C_ONEZ) ? 1 : 0;
        ms = m_next(ms, v, c, rx);
        step(v, c, rx, 1'b0);
        chk("R7/R12 random ind", ind_code, m_ind(ms));
        chk("R8/R10 random tx", tx_info, m_tx(ms));
        chk("R9 random loop", loop_en, (ms == M_LOOP) ? 1 : 0);
        chk("R11 random pulse", zero_pulse, ezp);
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule